// File: doc/BRIEF.md
# Add/Subtract Unit with Zero and Carry Flags

This block is a 32-bit integer arithmetic unit. It takes two operands and a 2-bit operation selector. It produces one of three values: the sum of the two operands, the first operand subtracted from the second (reverse subtraction), or the second operand subtracted from the first (forward subtraction). Alongside the result it reports whether the result is zero and the carry out of the most significant bit.

The arithmetic core is purely combinational and works in stages. The first stage conditions the operands for the chosen operation (one-sided inversion plus a carry-in of one for two's-complement subtraction). It then forms per-bit AND, OR and XOR terms. Four-bit groups turn these terms into group generate and group transmit signals. A lookahead level above the eight groups forms the carry into each group. The group sums, the zero flag and the final carry go through an output selection stage and into one register rank. Operands presented with `in_vld` high appear on the outputs one clock later. When `in_vld` is low the outputs keep their last value.

The reset input is asynchronous and active low. Inside the block its release is synchronised over two clock edges.

Top module: `addsub_flags`

## Requirements
- R1: With `op_sel` = 2'b00 and `in_vld` high, `result` equals (op_a + op_b) mod 2^32 on the clock edge after the operands are accepted.
- R2: With `op_sel` = 2'b01 and `in_vld` high, `result` equals (op_b - op_a) mod 2^32, formed by inverting op_a and adding a carry-in of one.
- R3: With `op_sel` = 2'b10 and `in_vld` high, `result` equals (op_a - op_b) mod 2^32, formed by inverting op_b and adding a carry-in of one.
- R4: The reserved code `op_sel` = 2'b11 behaves exactly like 2'b00 (addition, carry-in zero).
- R5: `zero_flag` is 1 exactly when all 32 bits of the registered `result` are 0.
- R6: `carry_flag` is the carry out of bit 31. For addition it is 1 when the unsigned sum exceeds 2^32 - 1. For both subtractions it is 1 when the minuend is greater than or equal to the subtrahend as unsigned numbers (no borrow).
- R7: `out_vld` equals `in_vld` delayed by one clock. While `in_vld` is low, `result`, `zero_flag` and `carry_flag` hold their previous values.
- R8: While reset is active, `out_vld`, `result`, `zero_flag` and `carry_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| in_vld | input | 1 | Operands valid; clock enable of the output register |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| op_sel | input | 2 | 00 add, 01 op_b minus op_a, 10 op_a minus op_b, 11 add |
| out_vld | output | 1 | Result valid, one clock after `in_vld` |
| result | output | 32 | Registered arithmetic result |
| zero_flag | output | 1 | Registered result is all zeros |
| carry_flag | output | 1 | Carry out of bit 31 (1 = no borrow for subtraction) |

## Verification
The assertions assume three things about the inputs. `in_vld` stays low until the internal reset release has passed through its two synchronising flops. `op_sel`, `op_a` and `op_b` carry known values whenever `in_vld` is high. The inputs change only between clock edges. The bench keeps to these assumptions: it holds `in_vld` low through reset and for several cycles after it, and it drives every input on the falling edge with fully defined values. Its stimulus mixes random operands under all four codes with all-zero, all-one, sign-bit-only and equal-operand cases under both subtractions.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  typedef enum logic [1:0] {
    OP_ADD     = 2'b00,
    OP_RSUB    = 2'b01,
    OP_SUB     = 2'b10,
    OP_ADD_ALT = 2'b11
  } addsub_op_e;

  localparam int unsigned DEF_WIDTH = 32;
  localparam int unsigned DEF_GRP   = 4;

endpackage

// File: rtl/addsub_precond.sv
module addsub_precond
  import addsub_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH
) (
  input  logic [WIDTH-1:0] opnd_x,
  input  logic [WIDTH-1:0] opnd_y,
  input  logic [1:0]       op_code,
  output logic [WIDTH-1:0] term_and,
  output logic [WIDTH-1:0] term_or,
  output logic [WIDTH-1:0] term_xor,
  output logic             carry_in
);

  logic [WIDTH-1:0] cond_x;
  logic [WIDTH-1:0] cond_y;

  always_comb begin
    cond_x   = opnd_x;
    cond_y   = opnd_y;
    carry_in = 1'b0;
    case (op_code)
      OP_RSUB: begin
        cond_x   = ~opnd_x;
        carry_in = 1'b1;
      end
      OP_SUB: begin
        cond_y   = ~opnd_y;
        carry_in = 1'b1;
      end
      default: begin
        cond_x   = opnd_x;
        cond_y   = opnd_y;
        carry_in = 1'b0;
      end
    endcase
  end

  always_comb begin
    term_and = cond_x & cond_y;
    term_or  = cond_x | cond_y;
    term_xor = cond_x ^ cond_y;
  end

endmodule

// File: rtl/addsub_cla_grp.sv
module addsub_cla_grp
  import addsub_pkg::*;
#(
  parameter int unsigned GRP = DEF_GRP
) (
  input  logic [GRP-1:0] bit_gen,
  input  logic [GRP-1:0] bit_xmit,
  input  logic [GRP-1:0] bit_half,
  input  logic           grp_cin,
  output logic [GRP-1:0] grp_sum,
  output logic           grp_gen,
  output logic           grp_xmit
);

  logic run_c;
  logic run_g;

  // ripple inside the short group, sum from half-sum and carry
  always_comb begin
    run_c = grp_cin;
    for (int i = 0; i < int'(GRP); i++) begin
      grp_sum[i] = bit_half[i] ^ run_c;
      run_c      = bit_gen[i] | (bit_xmit[i] & run_c);
    end
  end

  // group generate and transmit, independent of the carry-in
  always_comb begin
    run_g = 1'b0;
    for (int i = 0; i < int'(GRP); i++) begin
      run_g = bit_gen[i] | (bit_xmit[i] & run_g);
    end
    grp_gen  = run_g;
    grp_xmit = &bit_xmit;
  end

endmodule

// File: rtl/addsub_lookahead.sv
module addsub_lookahead
  import addsub_pkg::*;
#(
  parameter int unsigned NGRP = DEF_WIDTH / DEF_GRP
) (
  input  logic [NGRP-1:0] grp_gen,
  input  logic [NGRP-1:0] grp_xmit,
  input  logic            carry_in,
  output logic [NGRP-1:0] grp_cin,
  output logic            carry_out
);

  logic [NGRP:0] chain;

  assign chain[0] = carry_in;

  for (genvar k = 0; k < NGRP; k++) begin : g_level
    assign chain[k+1] = grp_gen[k] | (grp_xmit[k] & chain[k]);
    assign grp_cin[k] = chain[k];
  end

  assign carry_out = chain[NGRP];

endmodule

// File: rtl/addsub_flags.sv
module addsub_flags
  import addsub_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH,
  parameter int unsigned GRP   = DEF_GRP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [1:0]       op_sel,
  output logic             out_vld,
  output logic [WIDTH-1:0] result,
  output logic             zero_flag,
  output logic             carry_flag
);

  localparam int unsigned NGRP = WIDTH / GRP;

  // reset release synchroniser
  logic [1:0] rst_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q <= 2'b00;
    end else begin
      rst_q <= {rst_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_q[1];

  // stage 1: operand conditioning and bit terms
  logic [WIDTH-1:0] t_and;
  logic [WIDTH-1:0] t_or;
  logic [WIDTH-1:0] t_xor;
  logic             cin;

  addsub_precond #(.WIDTH(WIDTH)) u_precond (
    .opnd_x   (op_a),
    .opnd_y   (op_b),
    .op_code  (op_sel),
    .term_and (t_and),
    .term_or  (t_or),
    .term_xor (t_xor),
    .carry_in (cin)
  );

  // stage 2: group generate/transmit and group sums
  logic [NGRP-1:0]  g_gen;
  logic [NGRP-1:0]  g_xmit;
  logic [NGRP-1:0]  g_cin;
  logic [WIDTH-1:0] sum;
  logic             cout;

  for (genvar k = 0; k < NGRP; k++) begin : g_grp
    addsub_cla_grp #(.GRP(GRP)) u_grp (
      .bit_gen  (t_and[k*GRP +: GRP]),
      .bit_xmit (t_or[k*GRP +: GRP]),
      .bit_half (t_xor[k*GRP +: GRP]),
      .grp_cin  (g_cin[k]),
      .grp_sum  (sum[k*GRP +: GRP]),
      .grp_gen  (g_gen[k]),
      .grp_xmit (g_xmit[k])
    );
  end

  // stage 3: lookahead across groups
  addsub_lookahead #(.NGRP(NGRP)) u_look (
    .grp_gen   (g_gen),
    .grp_xmit  (g_xmit),
    .carry_in  (cin),
    .grp_cin   (g_cin),
    .carry_out (cout)
  );

  // stage 4: output selection (next state) and register
  logic [WIDTH-1:0] result_d;
  logic             zero_d;
  logic             carry_d;
  logic             vld_d;

  always_comb begin
    vld_d = in_vld;
    if (in_vld) begin
      result_d = sum;
      zero_d   = ~|sum;
      carry_d  = cout;
    end else begin
      result_d = result;
      zero_d   = zero_flag;
      carry_d  = carry_flag;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      out_vld    <= 1'b0;
      result     <= '0;
      zero_flag  <= 1'b0;
      carry_flag <= 1'b0;
    end else begin
      out_vld    <= vld_d;
      result     <= result_d;
      zero_flag  <= zero_d;
      carry_flag <= carry_d;
    end
  end

endmodule

// File: rtl/addsub_flags_chk.sv
module addsub_flags_chk #(
  parameter int unsigned WIDTH = 32
) (
  input logic             clk,
  input logic             rst_int_n,
  input logic             in_vld,
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic [1:0]       op_sel,
  input logic             out_vld,
  input logic [WIDTH-1:0] result,
  input logic             zero_flag,
  input logic             carry_flag
);

  logic [WIDTH-1:0] add_ref;
  logic [WIDTH-1:0] rsub_ref;
  logic [WIDTH-1:0] sub_ref;

  assign add_ref  = op_a + op_b;
  assign rsub_ref = op_b - op_a;
  assign sub_ref  = op_a - op_b;

  assert_add_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_vld && op_sel == 2'b00) |=> (result == $past(add_ref)));

  assert_rsub_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_vld && op_sel == 2'b01) |=> (result == $past(rsub_ref)));

  assert_sub_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_vld && op_sel == 2'b10) |=> (result == $past(sub_ref)));

  assert_alt_add_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_vld && op_sel == 2'b11) |=> (result == $past(add_ref)));

  assert_zero_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    out_vld |-> (zero_flag == (result == '0)));

  assert_noborrow_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_vld && op_sel == 2'b10) |=> (carry_flag == $past(op_a >= op_b)));

  assert_vld_delay_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    in_vld |=> out_vld);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    !in_vld |=> (!out_vld && $stable(result) && $stable(zero_flag) && $stable(carry_flag)));

  always @(negedge clk) begin
    if (rst_int_n == 1'b0) begin
      assert_reset_R8: assert (!out_vld && result == '0 && !zero_flag && !carry_flag);
    end
  end

endmodule

bind addsub_flags addsub_flags_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst_int_n  (rst_int_n),
  .in_vld     (in_vld),
  .op_a       (op_a),
  .op_b       (op_b),
  .op_sel     (op_sel),
  .out_vld    (out_vld),
  .result     (result),
  .zero_flag  (zero_flag),
  .carry_flag (carry_flag)
);

// File: tb/addsub_flags_test.sv
module addsub_flags_test;

  typedef struct {
    logic [31:0] res;
    logic [1:0]  op;
    logic        z;
    logic        c;
  } item_t;

  logic        clk;
  logic        rst_n;
  logic        in_vld;
  logic [31:0] op_a;
  logic [31:0] op_b;
  logic [1:0]  op_sel;
  logic        out_vld;
  logic [31:0] result;
  logic        zero_flag;
  logic        carry_flag;

  int    checks = 0;
  int    errors = 0;
  bit    done   = 0;
  item_t sb_q[$];
  item_t last_exp;

  addsub_flags uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_vld     (in_vld),
    .op_a       (op_a),
    .op_b       (op_b),
    .op_sel     (op_sel),
    .out_vld    (out_vld),
    .result     (result),
    .zero_flag  (zero_flag),
    .carry_flag (carry_flag)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [1:0] op);
    case (op)
      2'b00:   return "R1";
      2'b01:   return "R2";
      2'b10:   return "R3";
      default: return "R4";
    endcase
  endfunction

  // driver: present one operation and push its expected outcome
  task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic [1:0] op);
    item_t       e;
    logic [32:0] wide;
    @(negedge clk);
    in_vld = 1'b1;
    op_a   = a;
    op_b   = b;
    op_sel = op;
    e.op   = op;
    case (op)
      2'b01: begin e.res = b - a; e.c = (b >= a); end
      2'b10: begin e.res = a - b; e.c = (a >= b); end
      default: begin
        wide  = {1'b0, a} + {1'b0, b};
        e.res = wide[31:0];
        e.c   = wide[32];
      end
    endcase
    e.z = (e.res == 32'd0);
    sb_q.push_back(e);
    last_exp = e;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_vld = 1'b0;
    end
  endtask

  // monitor: pop and compare every valid result
  always @(negedge clk) begin
    if (rst_n && out_vld) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R7", "unexpected out_vld", 32'd1, 32'd0);
      end else begin
        item_t e;
        e = sb_q.pop_front();
        check(result == e.res, req_of(e.op), "result", result, e.res);
        check(zero_flag == e.z, "R5", "zero_flag", {31'd0, zero_flag}, {31'd0, e.z});
        check(carry_flag == e.c, "R6", "carry_flag", {31'd0, carry_flag}, {31'd0, e.c});
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R7 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n  = 1'b0;
    in_vld = 1'b0;
    op_a   = '0;
    op_b   = '0;
    op_sel = 2'b00;
    repeat (3) @(negedge clk);
    // R8: reset state
    check(out_vld == 1'b0, "R8", "out_vld in reset", {31'd0, out_vld}, 32'd0);
    check(result == 32'd0, "R8", "result in reset", result, 32'd0);
    check(zero_flag == 1'b0 && carry_flag == 1'b0, "R8", "flags in reset",
          {30'd0, zero_flag, carry_flag}, 32'd0);
    rst_n = 1'b1;
    idle(5);

    // corner cases
    drive(32'h0000_0000, 32'h0000_0000, 2'b00);  // R1 zero sum, R5 zero set
    drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b00);  // R1, R6 carry out
    drive(32'hFFFF_FFFF, 32'h0000_0001, 2'b00);  // R5 wrap to zero with carry
    drive(32'h8000_0000, 32'h8000_0000, 2'b00);  // R6 sign-bit carry
    drive(32'h8000_0000, 32'h8000_0000, 2'b11);  // R4 reserved code
    drive(32'h1234_5678, 32'h1234_5678, 2'b10);  // R3 equal, zero and no borrow
    drive(32'h1234_5678, 32'h1234_5678, 2'b01);  // R2 equal, zero and no borrow
    drive(32'h0000_0000, 32'h0000_0001, 2'b10);  // R3 borrow, carry 0
    drive(32'h0000_0001, 32'h0000_0000, 2'b01);  // R2 borrow, carry 0
    drive(32'h8000_0000, 32'h0000_0001, 2'b10);  // R3 sign boundary
    drive(32'h0000_0001, 32'h8000_0000, 2'b01);  // R2 sign boundary
    drive(32'h0000_0000, 32'hFFFF_FFFF, 2'b10);  // R3
    drive(32'hFFFF_FFFF, 32'h0000_0000, 2'b01);  // R2
    drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b11);  // R4
    drive(32'h0000_000F, 32'h0000_0001, 2'b00);  // R1 carry across a group

    // R7: hold while in_vld is low
    idle(4);
    check(out_vld == 1'b0, "R7", "out_vld idle", {31'd0, out_vld}, 32'd0);
    check(result == last_exp.res, "R7", "result held", result, last_exp.res);
    check(carry_flag == last_exp.c && zero_flag == last_exp.z, "R7", "flags held",
          {30'd0, zero_flag, carry_flag}, {30'd0, last_exp.z, last_exp.c});

    // random operands under every code, with gaps
    for (int n = 0; n < 400; n++) begin
      drive($urandom, $urandom, 2'(n % 4));
      if ((n % 7) == 3) idle(2);
    end
    for (int n = 0; n < 40; n++) begin
      logic [31:0] v;
      v = $urandom;
      drive(v, v, (n % 2 == 0) ? 2'b10 : 2'b01);  // R2/R3 equal operands
    end

    idle(4);
    check(sb_q.size() == 0, "R7", "scoreboard drained", sb_q.size(), 32'd0);
    check(result == last_exp.res, "R7", "final result held", result, last_exp.res);
    finish_run();
  end

endmodule